// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit interval timer channel. It advances on a clock-enable strobe (`tick`). Software programs it through a byte-wide port. A write to the control register picks one of six counting behaviours and sets how count bytes are transferred. Writes to the data register then load the count. The channel drives an output waveform whose shape depends on the selected behaviour: a terminal-count interrupt, a retriggerable one-shot, a periodic rate pulse, a square wave, or a software or hardware strobe. That output also drives an interrupt request line.

A `gate` input restarts the count on a rising edge in the behaviours that are retriggerable. The current count can be read live, or frozen into a holding register by a latch command and then read one byte at a time. Counting is binary only.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel runs in square-wave mode (mode 3) with an effective count of 65536 and word access. `out` is high, and it first goes low after 32768 ticks.
- R2: A write with `sel_ctrl`=1 and bits 5:4 not 00 is a control word. Bits 5:4 select access: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. Bits 3:1 select the mode, with 6 and 7 acting as 2 and 3. Bits 0, 6 and 7 are ignored. The control word stops counting and sets `out` low for modes 0 and 1, and high for modes 2 to 5.
- R3: Data writes load the count N. Low-only access clears the high byte, high-only access clears the low byte, and word access takes the low byte first and then the high byte. A written value of 0 means 65536. Elapsed ticks are counted from the first tick after the final byte.
- R4: In modes 0 and 1, `out` is low while elapsed ticks are below N. It goes high once they reach N and stays high.
- R5: In mode 2 (rate pulse), `out` is high except for one tick at each elapsed count that is a nonzero multiple of N.
- R6: In mode 3 (square wave), `out` is high for the first (N+1)>>1 ticks of each N-tick period and low for the rest.
- R7: In modes 4 and 5, `out` is low only at elapsed tick N and high before and after it.
- R8: A rising edge on `gate` resets the elapsed count to zero in modes 1, 2, 3 and 5. In modes 0 and 4 it has no effect.
- R9: A control write with bits 5:4 = 00 latches (N − elapsed) mod 65536. Data reads then return its bytes in the access order until the sequence is complete. A further latch command while a snapshot is held is ignored.
- R10: With no snapshot held, data reads return bytes of the live count (N − elapsed) mod 65536.
- R11: `irq` always carries the same level as `out`.
- R12: When `tick` is low, the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per counting step |
| gate | input | 1 | Gate; rising edge retriggers in modes 1, 2, 3, 5 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Data register read strobe (advances byte order) |
| sel_ctrl | input | 1 | 1 selects the control register, 0 the data register |
| wdata | input | BYTE_W | Write data byte |
| rdata | output | BYTE_W | Read data byte |
| out | output | 1 | Timer output waveform |
| irq | output | 1 | Interrupt request, equal to `out` |

## Verification
The bench builds the channel with `BYTE_W` = 8 and `GATE_SYNC` = 0. With these values a gate edge is acted on at the clock edge right after it is driven, so retrigger timing can be checked to the exact tick. A count of 65536 is also reachable in about 33k cycles, so the reset period and the zero-means-65536 rule are both exercised. Small counts (2 to 6) with both odd and even values cover the uneven square-wave split and the one-tick pulses.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      M_TC_INT  = 3'd0,
      M_ONESHOT = 3'd1,
      M_RATE    = 3'd2,
      M_SQUARE  = 3'd3,
      M_SW_STB  = 3'd4,
      M_HW_STB  = 3'd5
   } pit_mode_e;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_WORD  = 2'd3
   } pit_acc_e;

   localparam int CW_ACC_LSB  = 4;
   localparam int CW_MODE_LSB = 1;

   function automatic pit_mode_e norm_mode(input logic [2:0] f);
      case (f)
         3'd6:    return M_RATE;
         3'd7:    return M_SQUARE;
         default: return pit_mode_e'(f);
      endcase
   endfunction

   function automatic logic is_periodic(input pit_mode_e m);
      return (m == M_RATE) || (m == M_SQUARE);
   endfunction

   function automatic logic is_retrig(input pit_mode_e m);
      return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STB);
   endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   output logic rise
);
   logic g_s;
   logic g_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign g_s = gate;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= gate;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign g_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   // starts high so a gate held high through reset is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_d <= 1'b1;
      else        g_d <= g_s;
   end

   assign rise = g_s & ~g_d;
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  pit_mode_e        mode,
   input  logic             ctrl_stb,
   input  logic             load_stb,
   input  logic [CNT_W:0]   load_val,
   input  logic             grise,
   output logic [CNT_W-1:0] cur_cnt,
   output logic             out
);
   localparam int          PW   = CNT_W + 1;
   localparam logic [PW-1:0] FULL = PW'(1) << CNT_W;
   localparam logic [PW-1:0] ONE  = PW'(1);

   logic [PW-1:0] ph_q, ph_n, n_q, n_n, half;
   logic          wrap_q, wrap_n, run_q, run_n, out_q, out_n;

   always_comb begin
      ph_n   = ph_q;
      n_n    = n_q;
      wrap_n = wrap_q;
      run_n  = run_q;
      if (ctrl_stb) begin
         run_n  = 1'b0;
         ph_n   = '0;
         wrap_n = 1'b0;
      end else if (load_stb) begin
         n_n    = load_val;
         run_n  = 1'b1;
         ph_n   = '0;
         wrap_n = 1'b0;
      end else if (grise && run_q && is_retrig(mode)) begin
         ph_n   = '0;
         wrap_n = 1'b0;
      end else if (tick && run_q) begin
         if (is_periodic(mode)) begin
            if (ph_q + ONE == n_q) begin
               ph_n   = '0;
               wrap_n = 1'b1;
            end else begin
               ph_n = ph_q + ONE;
            end
         end else if (ph_q <= n_q) begin
            ph_n = ph_q + ONE;   // saturates one past the count
         end
      end

      half = (n_n + ONE) >> 1;
      case (mode)
         M_TC_INT, M_ONESHOT: out_n = (ph_n >= n_n);
         M_RATE:              out_n = !((ph_n == '0) && wrap_n);
         M_SQUARE:            out_n = (ph_n < half);
         default:             out_n = (ph_n != n_n);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         n_q    <= FULL;
         wrap_q <= 1'b0;
         run_q  <= 1'b1;
         out_q  <= 1'b1;
      end else begin
         ph_q   <= ph_n;
         n_q    <= n_n;
         wrap_q <= wrap_n;
         run_q  <= run_n;
         out_q  <= out_n;
      end
   end

   assign cur_cnt = CNT_W'(n_q - ph_q);
   assign out     = out_q;
endmodule

// File: rtl/pit_reg_if.sv
module pit_reg_if
   import pit_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              sel_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cur_cnt,
   output logic [BYTE_W-1:0] rdata,
   output pit_mode_e         mode_cur,
   output pit_mode_e         mode_nxt,
   output logic              ctrl_stb,
   output logic              load_stb,
   output logic [CNT_W:0]    load_val
);
   localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

   pit_mode_e          mode_q;
   pit_acc_e           acc_q, acc_n, acc_f;
   logic               wtog_q, wtog_n, rtog_q, rtog_n, lat_q, lat_n;
   logic [BYTE_W-1:0]  lo_q, lo_n;
   logic [CNT_W-1:0]   latv_q, latv_n, raw, src;

   assign acc_f = pit_acc_e'(wdata[CW_ACC_LSB +: 2]);

   always_comb begin
      mode_nxt = mode_q;
      acc_n    = acc_q;
      wtog_n   = wtog_q;
      rtog_n   = rtog_q;
      lat_n    = lat_q;
      latv_n   = latv_q;
      lo_n     = lo_q;
      ctrl_stb = 1'b0;
      load_stb = 1'b0;
      raw      = '0;

      if (rd_en && !sel_ctrl) begin
         if (acc_q == ACC_WORD) begin
            rtog_n = !rtog_q;
            if (rtog_q) lat_n = 1'b0;
         end else begin
            lat_n = 1'b0;
         end
      end

      if (wr_en && sel_ctrl) begin
         if (acc_f == ACC_LATCH) begin
            if (!lat_q) begin
               lat_n  = 1'b1;
               latv_n = cur_cnt;
               rtog_n = 1'b0;
            end
         end else begin
            ctrl_stb = 1'b1;
            mode_nxt = norm_mode(wdata[CW_MODE_LSB +: 3]);
            acc_n    = acc_f;
            wtog_n   = 1'b0;
            rtog_n   = 1'b0;
            lat_n    = 1'b0;
         end
      end else if (wr_en) begin
         case (acc_q)
            ACC_LO: begin
               load_stb = 1'b1;
               raw      = {{BYTE_W{1'b0}}, wdata};
            end
            ACC_HI: begin
               load_stb = 1'b1;
               raw      = {wdata, {BYTE_W{1'b0}}};
            end
            default: begin
               if (!wtog_q) begin
                  lo_n   = wdata;
                  wtog_n = 1'b1;
               end else begin
                  load_stb = 1'b1;
                  raw      = {wdata, lo_q};
                  wtog_n   = 1'b0;
               end
            end
         endcase
      end

      load_val = (raw == '0) ? FULL : {1'b0, raw};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_SQUARE;
         acc_q  <= ACC_WORD;
         wtog_q <= 1'b0;
         rtog_q <= 1'b0;
         lat_q  <= 1'b0;
         latv_q <= '0;
         lo_q   <= '0;
      end else begin
         mode_q <= mode_nxt;
         acc_q  <= acc_n;
         wtog_q <= wtog_n;
         rtog_q <= rtog_n;
         lat_q  <= lat_n;
         latv_q <= latv_n;
         lo_q   <= lo_n;
      end
   end

   assign src = lat_q ? latv_q : cur_cnt;

   always_comb begin
      case (acc_q)
         ACC_HI:   rdata = src[BYTE_W +: BYTE_W];
         ACC_WORD: rdata = rtog_q ? src[BYTE_W +: BYTE_W] : src[0 +: BYTE_W];
         default:  rdata = src[0 +: BYTE_W];
      endcase
   end

   assign mode_cur = mode_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int GATE_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              sel_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              out,
   output logic              irq
);
   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W < 6) begin : g_bad_byte
         $error("pit_channel: BYTE_W must hold the control fields (>= 6)");
      end
      if (GATE_SYNC < 0) begin : g_bad_sync
         $error("pit_channel: GATE_SYNC must not be negative");
      end
   endgenerate

   pit_mode_e        mode_cur, mode_nxt;
   logic             ctrl_stb, load_stb, gate_rise;
   logic [CNT_W:0]   load_val;
   logic [CNT_W-1:0] cur_cnt;

   pit_gate_edge #(.SYNC_STAGES(GATE_SYNC)) u_gate (
      .clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise)
   );

   pit_reg_if #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .sel_ctrl(sel_ctrl), .wdata(wdata), .cur_cnt(cur_cnt), .rdata(rdata),
      .mode_cur(mode_cur), .mode_nxt(mode_nxt), .ctrl_stb(ctrl_stb),
      .load_stb(load_stb), .load_val(load_val)
   );

   pit_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_nxt),
      .ctrl_stb(ctrl_stb), .load_stb(load_stb), .load_val(load_val),
      .grise(gate_rise), .cur_cnt(cur_cnt), .out(out)
   );

   assign irq = out;
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
   import pit_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic              sel_ctrl,
   input logic [BYTE_W-1:0] wdata,
   input logic              out,
   input pit_mode_e         mode_cur,
   input logic              grise,
   input logic [CNT_W-1:0]  cnt
);
   logic cw_wr;
   assign cw_wr = wr_en && sel_ctrl && (wdata[CW_ACC_LSB +: 2] != 2'b00);

   AST_CW_LOW_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      cw_wr && (wdata[CW_MODE_LSB +: 3] inside {3'd0, 3'd1}) |=> !out); // R2

   AST_CW_HIGH_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      cw_wr && !(wdata[CW_MODE_LSB +: 3] inside {3'd0, 3'd1}) |=> out); // R2

   AST_ONESHOT_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) && (mode_cur inside {M_TC_INT, M_ONESHOT}) |-> !$fell(out)); // R4

   AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cur inside {M_SW_STB, M_HW_STB}) && !out && tick && !wr_en |=> out); // R7

   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr_en && !grise |=> $stable(cnt)); // R12
endmodule

bind pit_channel pit_channel_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .sel_ctrl(sel_ctrl),
   .wdata(wdata), .out(out), .mode_cur(mode_cur), .grise(gate_rise), .cnt(cur_cnt)
);

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, gate = 1'b0, wr_en = 1'b0, rd_en = 1'b0, sel_ctrl = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, b;
   logic       out, irq;
   int         checks = 0;
   int         fails = 0;

   always #2.5 clk = ~clk;

   pit_channel #(.BYTE_W(8), .GATE_SYNC(0)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .wr_en(wr_en),
      .rd_en(rd_en), .sel_ctrl(sel_ctrl), .wdata(wdata), .rdata(rdata),
      .out(out), .irq(irq)
   );

   // vector table: control word, count, ticks to run
   localparam int NV = 10;
   localparam int VCW [NV] = '{8'h30, 8'h32, 8'h34, 8'h35, 8'h36, 8'h36, 8'h38, 8'h3A, 8'h3C, 8'hFE};
   localparam int VN  [NV] = '{5, 3, 4, 3, 5, 6, 4, 2, 3, 3};
   localparam int VT  [NV] = '{8, 6, 13, 10, 16, 14, 8, 6, 8, 9};

   function automatic logic exp_out(input int cw, input int n, input int d);
      int m;
      m = (cw >> 1) & 7;
      if (m > 5) m = m - 4;
      case (m)
         0, 1:    return d >= n;
         2:       return !((d != 0) && (d % n == 0));
         3:       return (d % n) < ((n + 1) / 2);
         default: return d != n;
      endcase
   endfunction

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic [7:0] d);
      @(negedge clk); sel_ctrl = c; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk); sel_ctrl = 1'b0; rd_en = 1'b1; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic run(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset out", out, 1);
      chk("R11 reset irq", irq, 1);
      wr(1'b1, 8'h00);                     // latch command
      rd(b); chk("R9 R1 reset count lo", b, 8'h00);
      rd(b); chk("R9 R1 reset count hi", b, 8'h00);
      run(32767); chk("R1 high before half period", out, 1);
      run(1);     chk("R1 low at half of 65536", out, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         wr(1'b1, 8'(VCW[v]));
         chk("R2 initial level", out, exp_out(VCW[v], VN[v], 0));
         wr(1'b0, 8'(VN[v]));
         wr(1'b0, 8'h00);
         tick = 1'b1;
         for (int k = 1; k <= VT[v]; k++) begin
            @(negedge clk);
            chk("R4 R5 R6 R7 waveform", out, exp_out(VCW[v], VN[v], k));
            chk("R11 irq follows out", irq, out);
         end
         tick = 1'b0;
      end

      // R3 zero load means 65536
      wr(1'b1, 8'h30); wr(1'b0, 8'h00); wr(1'b0, 8'h00);
      run(3);
      wr(1'b1, 8'h00);
      rd(b); chk("R3 R9 zero load lo", b, 8'hFD);
      rd(b); chk("R3 R9 zero load hi", b, 8'hFF);

      // R3 low-only access, R10 live read
      wr(1'b1, 8'h10); wr(1'b0, 8'h07);
      run(2);
      rd(b); chk("R10 live low byte", b, 8'h05);
      run(4); chk("R3 lo-only below count", out, 0);
      run(1); chk("R3 lo-only at count", out, 1);

      // R3 high-only access: N = 256
      wr(1'b1, 8'h20); wr(1'b0, 8'h01);
      run(255); chk("R3 hi-only below 256", out, 0);
      run(1);   chk("R3 hi-only at 256", out, 1);

      // R9 latch held, second latch ignored
      wr(1'b1, 8'h34); wr(1'b0, 8'h64); wr(1'b0, 8'h00);
      run(10);
      wr(1'b1, 8'h00);
      run(5);
      wr(1'b1, 8'h00);
      rd(b); chk("R9 held snapshot lo", b, 8'h5A);
      rd(b); chk("R9 held snapshot hi", b, 8'h00);
      rd(b); chk("R10 live after release lo", b, 8'h55);
      rd(b); chk("R10 live after release hi", b, 8'h00);

      // R8 gate retrigger in mode 1
      wr(1'b1, 8'h32); wr(1'b0, 8'h05); wr(1'b0, 8'h00);
      run(3);
      @(negedge clk); gate = 1'b1;
      @(negedge clk);
      run(4); chk("R8 mode1 restarted, still low", out, 0);
      run(1); chk("R8 mode1 reaches count after restart", out, 1);

      // R8 gate ignored in mode 0
      wr(1'b1, 8'h30); wr(1'b0, 8'h05); wr(1'b0, 8'h00);
      run(3);
      @(negedge clk); gate = 1'b0;
      @(negedge clk); gate = 1'b1;
      @(negedge clk);
      run(2); chk("R8 mode0 gate no restart", out, 1);

      // R2 control word stops counting
      wr(1'b1, 8'h30); wr(1'b0, 8'h03); wr(1'b0, 8'h00);
      run(3); chk("R4 mode0 reached count", out, 1);
      wr(1'b1, 8'h30);
      chk("R2 control write drops out", out, 0);
      run(6); chk("R2 stopped after control write", out, 0);

      // R12 tick low holds the count
      wr(1'b1, 8'h30); wr(1'b0, 8'h02); wr(1'b0, 8'h00);
      repeat (10) @(negedge clk);
      chk("R12 no advance without tick", out, 0);
      rd(b); chk("R12 count unchanged lo", b, 8'h02);
      rd(b);
      run(2); chk("R12 advances with tick", out, 1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule